// File: doc/BRIEF.md
# Fractional audio clock generator

This block derives an audio master clock and a bit clock from a fast peripheral clock. All logic runs on the peripheral clock. A fractional rate stage adds a numerator X to an accumulator on every cycle. Each time the running sum reaches the denominator Y, the stage subtracts Y and raises a one-cycle tick. Each tick flips the master-clock level, so the master clock runs at the peripheral rate times X/Y, halved.

A programmable integer divider counts the master-clock edges, meaning the ticks. Every D+1 of them it flips the bit-clock level, so the bit clock runs at the master-clock rate divided by D+1. For example, 16-bit stereo audio at 48 kHz needs a 1.536 MHz bit clock. When the bit clock rises, the block raises a one-cycle enable pulse that a serializer can use to advance one bit. A separate enable decides whether the master clock is driven out. Zero or inconsistent ratio settings stop the clocks.

Top module: `audclk_gen`

## Requirements
- R1: While reset is held, mclk_tick, mclk_out, bclk_en and bclk_out are all 0, and the internal accumulator, the clock levels and the divider count are cleared.
- R2: After a ratio restart, take k as the number of cycles since the restart, counting from 0, with X and Y held. mclk_tick is high in cycle k exactly when floor((k+1)*X/Y) > floor(k*X/Y). This is the cycle in which accumulator + X >= Y.
- R3: While rate_num or rate_den is zero, mclk_tick stays low and both clock levels hold their value.
- R4: While rate_num > rate_den, the setting is invalid: mclk_tick stays low and the levels hold.
- R5: With mclk_oe high, mclk_out toggles at the clock edge that ends every cycle in which mclk_tick is high, and at no other edge. Its frequency is therefore f_pclk*X/Y/2.
- R6: While mclk_oe is low, mclk_out is 0. The master-clock phase keeps advancing and shows up again once mclk_oe returns high.
- R7: bclk_out toggles at the edge that ends the (D+1)-th tick counted since the previous toggle, or since a divider restart. D is bit_div, from 0 to 63, so the bit clock is the master clock divided by D+1.
- R8: bclk_en is high for exactly one cycle: the first cycle after each rising edge of bclk_out. It is never high otherwise.
- R9: In any cycle where rate_num or rate_den differs from its value in the previous cycle (the values after reset count as 0), mclk_tick is low and the accumulator is cleared. k restarts at 0 in the next cycle.
- R10: In any cycle where bit_div differs from its previous value (0 after reset), the tick counter is cleared and that cycle's tick does not advance the bit clock. mclk_out still toggles on that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_num | input | 8 | Fractional numerator X |
| rate_den | input | 8 | Fractional denominator Y |
| bit_div | input | 6 | Bit clock divider D (divide by D+1) |
| mclk_oe | input | 1 | Master clock output enable |
| mclk_tick | output | 1 | One-cycle tick at each master-clock edge |
| mclk_out | output | 1 | Master clock level, gated by mclk_oe |
| bclk_en | output | 1 | One-cycle pulse after each bit-clock rise |
| bclk_out | output | 1 | Bit clock level |

## Verification
The assertions assume that the ratio and divider inputs change only between clock edges. They also assume that no change is expected to produce a tick in its own cycle, and that the bit clock moves only on cycles with a tick. The stimulus drives every input one time step after the rising edge and holds it for whole segments of several hundred cycles. Most random segments pick X between 1 and Y. About one segment in eight deliberately uses a zero or an X greater than Y to exercise the invalid settings. Directed cases cover X equal to Y, divide-by-one, and toggling the master-clock enable.

// File: rtl/audclk_pkg.sv
package audclk_pkg;
  localparam int RATE_W = 8;
  localparam int DIV_W  = 6;

  typedef struct packed {
    logic [RATE_W-1:0] acc;
    logic              tick;
  } frac_step_t;

  function automatic logic ratio_ok(input logic [RATE_W-1:0] num,
                                    input logic [RATE_W-1:0] den);
    return (num != '0) && (den != '0) && (num <= den);
  endfunction

  function automatic frac_step_t frac_step(input logic [RATE_W-1:0] acc,
                                           input logic [RATE_W-1:0] num,
                                           input logic [RATE_W-1:0] den);
    frac_step_t r;
    logic [RATE_W:0] sum;
    sum = {1'b0, acc} + {1'b0, num};
    if (sum >= {1'b0, den}) begin
      r.tick = 1'b1;
      r.acc  = RATE_W'(sum - {1'b0, den});
    end else begin
      r.tick = 1'b0;
      r.acc  = sum[RATE_W-1:0];
    end
    return r;
  endfunction
endpackage

// File: rtl/audclk_frac_acc.sv
module audclk_frac_acc
  import audclk_pkg::*;
#(
  parameter int W = RATE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         tick,
  output logic         restart
);
  logic [W-1:0] acc_q;
  logic [W-1:0] num_q;
  logic [W-1:0] den_q;
  logic         valid;
  frac_step_t   step;

  always_comb begin
    restart = (num != num_q) || (den != den_q);
    valid   = ratio_ok(num, den);
    step    = frac_step(acc_q, num, den);
    tick    = valid && !restart && step.tick;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      num_q <= '0;
      den_q <= '0;
    end else if (restart) begin
      acc_q <= '0;
      num_q <= num;
      den_q <= den;
    end else if (valid) begin
      acc_q <= step.acc;
    end
  end
endmodule

// File: rtl/audclk_mclk_stage.sv
module audclk_mclk_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic oe,
  output logic lvl,
  output logic out
);
  always_ff @(posedge clk) begin
    if (!rst_n)    lvl <= 1'b0;
    else if (tick) lvl <= ~lvl;
  end

  assign out = lvl & oe;
endmodule

// File: rtl/audclk_bit_div.sv
module audclk_bit_div
  import audclk_pkg::*;
#(
  parameter int W = DIV_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] div,
  output logic         wrap,
  output logic         restart,
  output logic         lvl,
  output logic         en
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] div_q;

  always_comb begin
    restart = (div != div_q);
    wrap    = tick && !restart && (cnt_q == div);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      div_q <= '0;
      lvl   <= 1'b0;
      en    <= 1'b0;
    end else begin
      en <= 1'b0;
      if (restart) begin
        cnt_q <= '0;
        div_q <= div;
      end else if (wrap) begin
        cnt_q <= '0;
        lvl   <= ~lvl;
        en    <= ~lvl;
      end else if (tick) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/audclk_gen.sv
module audclk_gen
  import audclk_pkg::*;
#(
  parameter int RW = RATE_W,
  parameter int DW = DIV_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] rate_num,
  input  logic [RW-1:0] rate_den,
  input  logic [DW-1:0] bit_div,
  input  logic          mclk_oe,
  output logic          mclk_tick,
  output logic          mclk_out,
  output logic          bclk_en,
  output logic          bclk_out
);
  logic frac_tick;
  logic ratio_restart;
  logic mclk_lvl;
  logic bit_wrap;
  logic div_restart;

  audclk_frac_acc #(.W(RW)) frac_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .num     (rate_num),
    .den     (rate_den),
    .tick    (frac_tick),
    .restart (ratio_restart)
  );

  audclk_mclk_stage mclk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (frac_tick),
    .oe    (mclk_oe),
    .lvl   (mclk_lvl),
    .out   (mclk_out)
  );

  audclk_bit_div #(.W(DW)) bdiv_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (frac_tick),
    .div     (bit_div),
    .wrap    (bit_wrap),
    .restart (div_restart),
    .lvl     (bclk_out),
    .en      (bclk_en)
  );

  assign mclk_tick = frac_tick;
endmodule

// File: rtl/audclk_gen_chk.sv
module audclk_gen_chk
  import audclk_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [RATE_W-1:0] rate_num,
  input logic [RATE_W-1:0] rate_den,
  input logic              mclk_oe,
  input logic              mclk_tick,
  input logic              mclk_out,
  input logic              mclk_lvl,
  input logic              bclk_en,
  input logic              bclk_out
);
  logic [RATE_W-1:0] num_seen;
  logic [RATE_W-1:0] den_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      num_seen <= '0;
      den_seen <= '0;
    end else begin
      num_seen <= rate_num;
      den_seen <= rate_den;
    end
  end

  // R3
  zero_ratio_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_num == '0 || rate_den == '0) |-> !mclk_tick);

  // R4
  num_over_den_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_num > rate_den) |-> !mclk_tick);

  // R9
  ratio_change_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_num != num_seen || rate_den != den_seen) |-> !mclk_tick);

  // R5
  mclk_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mclk_tick |=> $stable(mclk_lvl));

  // R6
  mclk_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mclk_oe |-> !mclk_out);

  // R7
  bclk_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mclk_tick |=> $stable(bclk_out));

  // R8
  bclk_en_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_en |-> (bclk_out && !$past(bclk_out)));

  // R8
  bclk_en_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_en |=> !bclk_en);
endmodule

bind audclk_gen audclk_gen_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .rate_num  (rate_num),
  .rate_den  (rate_den),
  .mclk_oe   (mclk_oe),
  .mclk_tick (mclk_tick),
  .mclk_out  (mclk_out),
  .mclk_lvl  (mclk_lvl),
  .bclk_en   (bclk_en),
  .bclk_out  (bclk_out)
);

// File: tb/audclk_gen_tb.sv
module audclk_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] rate_num = '0;
  logic [7:0] rate_den = '0;
  logic [5:0] bit_div = '0;
  logic       mclk_oe = 1'b0;
  logic       mclk_tick, mclk_out, bclk_en, bclk_out;

  int total = 0;
  int bad = 0;
  bit chk_on = 1'b0;
  bit done = 1'b0;

  // bench model state
  longint  k = 0;
  int      px = 0, py = 0, pd = 0;
  bit      m_lvl = 0, b_lvl = 0, b_en = 0;
  int      b_cnt = 0;
  bit      prev_cfg_chg = 0;
  int      tog_cnt = 0;

  always #4 clk = ~clk;

  audclk_gen dut_i (
    .clk(clk), .rst_n(rst_n), .rate_num(rate_num), .rate_den(rate_den),
    .bit_div(bit_div), .mclk_oe(mclk_oe), .mclk_tick(mclk_tick),
    .mclk_out(mclk_out), .bclk_en(bclk_en), .bclk_out(bclk_out)
  );

  function automatic bit cfg_good(int x, int y);
    return x > 0 && y > 0 && x <= y;
  endfunction

  function automatic bit exp_tick();
    longint x = longint'(rate_num);
    longint y = longint'(rate_den);
    if (!cfg_good(int'(x), int'(y))) return 0;
    if (int'(x) != px || int'(y) != py) return 0;
    return ((k + 1) * x / y) > (k * x / y);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      k = 0; px = 0; py = 0; pd = 0;
      m_lvl = 0; b_lvl = 0; b_en = 0; b_cnt = 0;
    end else begin
      bit t;
      t = exp_tick();
      if (int'(rate_num) != px || int'(rate_den) != py) begin
        k = 0; px = int'(rate_num); py = int'(rate_den);
      end else if (cfg_good(px, py)) begin
        k++;
      end
      if (t) begin m_lvl = ~m_lvl; tog_cnt++; end
      b_en = 0;
      if (int'(bit_div) != pd) begin
        pd = int'(bit_div); b_cnt = 0;
      end else if (t) begin
        if (b_cnt == pd) begin
          b_cnt = 0;
          if (!b_lvl) b_en = 1;
          b_lvl = ~b_lvl;
        end else b_cnt++;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst_n && chk_on) begin
      check(!mclk_tick && !mclk_out && !bclk_en && !bclk_out, "R1",
            {mclk_tick, mclk_out, bclk_en, bclk_out}, 0);
    end else if (rst_n && chk_on) begin
      string tr;
      string mr;
      if (rate_num == 0 || rate_den == 0) tr = "R3";
      else if (rate_num > rate_den) tr = "R4";
      else if (int'(rate_num) != px || int'(rate_den) != py) tr = "R9";
      else tr = "R2";
      check(mclk_tick == exp_tick(), tr, mclk_tick, exp_tick());
      mr = mclk_oe ? "R5" : "R6";
      check(mclk_out == (m_lvl & mclk_oe), mr, mclk_out, m_lvl & mclk_oe);
      check(bclk_out == b_lvl, (int'(bit_div) != pd) ? "R10" : "R7", bclk_out, b_lvl);
      check(bclk_en == b_en, "R8", bclk_en, b_en);
    end
  end

  task automatic run(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic set_cfg(int x, int y, int d, bit oe);
    @(posedge clk); #1;
    rate_num = 8'(x); rate_den = 8'(y); bit_div = 6'(d); mclk_oe = oe;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed = 32'h1a2b;
    void'($urandom(seed));
    // R1: reset with nonzero inputs applied
    rate_num = 8'd3; rate_den = 8'd7; bit_div = 6'd2; mclk_oe = 1'b1;
    chk_on = 1'b1;
    run(5);
    @(posedge clk); #1 rst_n = 1'b1;
    run(200);
    // R2 R5: toggle count over a window equals floor(n*X/Y)
    set_cfg(3, 7, 2, 1);
    set_cfg(3, 8, 2, 1);
    @(posedge clk); #1 tog_cnt = 0;
    run(1400);
    #1 check(tog_cnt == 525, "R5", tog_cnt, 525);
    // R3 zero values, R4 num above den
    set_cfg(0, 9, 1, 1); run(100);
    set_cfg(9, 0, 1, 1); run(100);
    set_cfg(9, 4, 1, 1); run(100);
    // X == Y: tick every cycle, divide by one
    set_cfg(200, 200, 0, 1); run(100);
    // R6: gated then re-enabled
    set_cfg(1, 3, 1, 0); run(150);
    set_cfg(1, 3, 1, 1); run(150);
    // R10: divider changes while running
    set_cfg(1, 2, 5, 1); run(37);
    set_cfg(1, 2, 3, 1); run(61);
    set_cfg(1, 2, 63, 1); run(400);
    // random segments
    for (int s = 0; s < 40; s++) begin
      int y = 1 + int'($urandom_range(254));
      int x = 1 + int'($urandom_range(y - 1));
      int d = int'($urandom_range(63));
      if ($urandom_range(7) == 0) begin
        if ($urandom_range(1) == 0) x = 0; else begin x = 255; y = 1 + int'($urandom_range(200)); end
      end
      set_cfg(x, y, d, bit'($urandom_range(3) != 0));
      run(300 + int'($urandom_range(1200)));
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule